// File: doc/BRIEF.md
# Background-Pattern Memory Readback Tester

This block is a built-in self-test sequencer for one synchronous single-port RAM. A one-cycle start request runs four screening passes. Each pass uses its own fixed data background. The first pass fills the whole array with zeros, which exposes cells stuck at one. The second fills it with ones, which exposes cells stuck at zero. The last two passes use a checkerboard and then its complement, so that neighbouring bits and neighbouring words hold opposite values. A wired-AND or wired-OR short between adjacent cells then shows up as a wrong bit.

A pass has two phases. The write phase stores every word. The read phase then fetches every word back and compares it with the background. Faults are judged only on this readback. The tester keeps a sticky fail flag for the whole run. It also keeps a snapshot of the first mismatch: the address, the pass in which it occurred, and the bitwise difference between expected and returned data. After the final comparison the tester raises a done flag, and a pass flag that is valid while done is high. The array depth need not be a power of two, because a parameter sets the last address of each phase.

Top module: `bgpat_mem_tester`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) returns the tester to idle. After reset, done_o, pass_o, mem_we_o and all fail_* outputs are 0.
- R2: start_i is acted on only while the tester is idle. A start request during a run has no effect on the memory-port sequence.
- R3: After an accepted start, the port issues one operation per cycle, with no gaps, beginning in the cycle after start is sampled. There are four passes with pattern index 0 = all zeros, 1 = all ones, 2 = checkerboard and 3 = inverted checkerboard. Each pass writes addresses 0..LAST_ADDR in ascending order with mem_we_o=1 and the background on mem_wdata_o. It then reads 0..LAST_ADDR in ascending order with mem_we_o=0.
- R4: In the checkerboard background, bit i of the word at address a equals (i mod 2) XOR (a mod 2). The inverted checkerboard is its bitwise complement.
- R5: mem_addr_o never exceeds LAST_ADDR while an operation is issued.
- R6: Read data is taken from mem_rdata_i in the cycle after the read address is presented. This includes the read of LAST_ADDR in the final pass.
- R7: done_o rises one cycle after the cycle that follows the last read. It stays high until the next accepted start. pass_o is high exactly when done_o is high and no mismatch was seen in the run.
- R8: On the first mismatch of a run, fail_addr_o, fail_pat_o (pattern index as in R3) and fail_mask_o (expected XOR read) are captured. Later mismatches leave them unchanged.
- R9: The fail indication is sticky. A run with mismatches still completes all four passes before done_o rises.
- R10: An accepted start clears done_o, the fail indication and the captured fields of the previous run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Run request, sampled only when idle |
| done_o | output | 1 | Run finished; held until next start |
| pass_o | output | 1 | No mismatch in the run, valid with done_o |
| mem_addr_o | output | ADDR_W | Memory word address |
| mem_we_o | output | 1 | Memory write enable |
| mem_wdata_o | output | DATA_W | Memory write data (background word) |
| mem_rdata_i | input | DATA_W | Memory read data, one cycle after address |
| fail_addr_o | output | ADDR_W | Address of the first mismatch |
| fail_pat_o | output | 2 | Pattern index of the first mismatch |
| fail_mask_o | output | DATA_W | Expected XOR read for the first mismatch |

## Verification
The assertions assume that the attached RAM returns data exactly one cycle after a read address. They also assume that rst is held for at least one clock before any start, and that the design's outputs are the only driver of the memory. The bench meets these assumptions with a behavioural RAM of that latency, with optional fault injection on each cycle. It drives start and reset only at falling edges, a whole cycle after any earlier reset. Start requests in the middle of a run are issued deliberately to show that they are ignored.

// File: rtl/bgpat_pkg.sv
package bgpat_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WRITE = 2'd1,
    ST_READ  = 2'd2,
    ST_DRAIN = 2'd3
  } tst_state_e;

  localparam int PAT_W    = 2;
  localparam int NUM_PATS = 4;

  // One bit of a background word: idx selects zeros, ones, checker, inverted.
  function automatic logic bg_bit(input logic [PAT_W-1:0] idx,
                                  input logic col_lsb,
                                  input logic row_lsb);
    logic chk;
    chk = col_lsb ^ row_lsb;
    case (idx)
      2'd0:    bg_bit = 1'b0;
      2'd1:    bg_bit = 1'b1;
      2'd2:    bg_bit = chk;
      default: bg_bit = ~chk;
    endcase
  endfunction

endpackage

// File: rtl/bgpat_seq.sv
module bgpat_seq
  import bgpat_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int LAST_ADDR = 44
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  output tst_state_e        state_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [PAT_W-1:0]  pat_o,
  output logic              start_acc_o,
  output logic              rd_issue_o,
  output logic              run_end_o
);

  localparam logic [ADDR_W-1:0] LAST_A   = ADDR_W'(LAST_ADDR);
  localparam logic [PAT_W-1:0]  LAST_PAT = PAT_W'(NUM_PATS - 1);

  tst_state_e        state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [PAT_W-1:0]  pat_q;
  logic              last_hit;

  assign last_hit    = (addr_q == LAST_A);
  assign start_acc_o = (state_q == ST_IDLE) && start_i;
  assign rd_issue_o  = (state_q == ST_READ);
  assign run_end_o   = (state_q == ST_DRAIN);
  assign state_o     = state_q;
  assign addr_o      = addr_q;
  assign pat_o       = pat_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      pat_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q <= ST_WRITE;
            addr_q  <= '0;
            pat_q   <= '0;
          end
        end
        ST_WRITE: begin
          if (last_hit) begin
            state_q <= ST_READ;
            addr_q  <= '0;
          end else begin
            addr_q <= addr_q + 1'b1;
          end
        end
        ST_READ: begin
          if (last_hit) begin
            addr_q <= '0;
            if (pat_q == LAST_PAT) begin
              state_q <= ST_DRAIN;
            end else begin
              pat_q   <= pat_q + 1'b1;
              state_q <= ST_WRITE;
            end
          end else begin
            addr_q <= addr_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_addr_in_range_R5: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WRITE || state_q == ST_READ) |-> (addr_q <= LAST_A));

  assert_next_pattern_R3: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_READ && last_hit && pat_q != LAST_PAT)
      |=> (state_q == ST_WRITE && pat_q == $past(pat_q) + 2'd1 && addr_q == '0));

  assert_busy_ignores_start_R2: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WRITE && !last_hit) |=> (state_q == ST_WRITE && addr_q == $past(addr_q) + 1'b1));

endmodule

// File: rtl/bgpat_check.sv
module bgpat_check
  import bgpat_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear_i,
  input  logic              rd_issue_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [PAT_W-1:0]  rd_pat_i,
  input  logic [DATA_W-1:0] exp_i,
  input  logic [DATA_W-1:0] rdata_i,
  input  logic              run_end_i,
  output logic              cmp_vld_o,
  output logic              done_o,
  output logic              fail_o,
  output logic [ADDR_W-1:0] cap_addr_o,
  output logic [PAT_W-1:0]  cap_pat_o,
  output logic [DATA_W-1:0] cap_mask_o
);

  logic              vld_q;
  logic [DATA_W-1:0] exp_q;
  logic [ADDR_W-1:0] addr_q;
  logic [PAT_W-1:0]  pat_q;
  logic [DATA_W-1:0] diff;
  logic              mismatch;
  logic              done_q, fail_q;
  logic [ADDR_W-1:0] cap_addr_q;
  logic [PAT_W-1:0]  cap_pat_q;
  logic [DATA_W-1:0] cap_mask_q;

  assign diff     = rdata_i ^ exp_q;
  assign mismatch = vld_q && (diff != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q      <= 1'b0;
      exp_q      <= '0;
      addr_q     <= '0;
      pat_q      <= '0;
      done_q     <= 1'b0;
      fail_q     <= 1'b0;
      cap_addr_q <= '0;
      cap_pat_q  <= '0;
      cap_mask_q <= '0;
    end else begin
      vld_q  <= rd_issue_i;
      exp_q  <= exp_i;
      addr_q <= rd_addr_i;
      pat_q  <= rd_pat_i;
      if (clear_i) begin
        done_q     <= 1'b0;
        fail_q     <= 1'b0;
        cap_addr_q <= '0;
        cap_pat_q  <= '0;
        cap_mask_q <= '0;
      end else begin
        if (mismatch && !fail_q) begin
          cap_addr_q <= addr_q;
          cap_pat_q  <= pat_q;
          cap_mask_q <= diff;
        end
        if (mismatch)  fail_q <= 1'b1;
        if (run_end_i) done_q <= 1'b1;
      end
    end
  end

  assign cmp_vld_o  = vld_q;
  assign done_o     = done_q;
  assign fail_o     = fail_q;
  assign cap_addr_o = cap_addr_q;
  assign cap_pat_o  = cap_pat_q;
  assign cap_mask_o = cap_mask_q;

  assert_fail_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (fail_q && !clear_i) |=> fail_q);

  assert_capture_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (fail_q && !clear_i) |=> ($stable(cap_addr_q) && $stable(cap_pat_q) && $stable(cap_mask_q)));

  assert_mask_nonzero_R8: assert property (@(posedge clk) disable iff (rst)
    fail_q |-> ($countones(cap_mask_q) > 0));

  assert_done_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (done_q && !clear_i) |=> done_q);

  assert_start_clears_R10: assert property (@(posedge clk) disable iff (rst)
    clear_i |=> (!done_q && !fail_q && cap_mask_q == '0));

endmodule

// File: rtl/bgpat_mem_tester.sv
module bgpat_mem_tester
  import bgpat_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 8,
  parameter int LAST_ADDR = 44
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  output logic              done_o,
  output logic              pass_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_we_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [ADDR_W-1:0] fail_addr_o,
  output logic [1:0]        fail_pat_o,
  output logic [DATA_W-1:0] fail_mask_o
);

  tst_state_e        seq_state;
  logic [ADDR_W-1:0] seq_addr;
  logic [PAT_W-1:0]  seq_pat;
  logic              start_acc, rd_issue, run_end;
  logic              cmp_vld, chk_done, chk_fail;
  logic [DATA_W-1:0] bg_word;

  bgpat_seq #(.ADDR_W(ADDR_W), .LAST_ADDR(LAST_ADDR)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .state_o     (seq_state),
    .addr_o      (seq_addr),
    .pat_o       (seq_pat),
    .start_acc_o (start_acc),
    .rd_issue_o  (rd_issue),
    .run_end_o   (run_end)
  );

  for (genvar b = 0; b < DATA_W; b++) begin : g_bg
    localparam logic COL_LSB = 1'(b % 2);
    assign bg_word[b] = bg_bit(seq_pat, COL_LSB, seq_addr[0]);
  end

  bgpat_check #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_check (
    .clk        (clk),
    .rst        (rst),
    .clear_i    (start_acc),
    .rd_issue_i (rd_issue),
    .rd_addr_i  (seq_addr),
    .rd_pat_i   (seq_pat),
    .exp_i      (bg_word),
    .rdata_i    (mem_rdata_i),
    .run_end_i  (run_end),
    .cmp_vld_o  (cmp_vld),
    .done_o     (chk_done),
    .fail_o     (chk_fail),
    .cap_addr_o (fail_addr_o),
    .cap_pat_o  (fail_pat_o),
    .cap_mask_o (fail_mask_o)
  );

  assign mem_addr_o  = seq_addr;
  assign mem_we_o    = (seq_state == ST_WRITE);
  assign mem_wdata_o = bg_word;
  assign done_o      = chk_done;
  assign pass_o      = chk_done && !chk_fail;

  assert_read_then_compare_R6: assert property (@(posedge clk) disable iff (rst)
    rd_issue |=> cmp_vld);

  assert_pass_needs_done_R7: assert property (@(posedge clk) disable iff (rst)
    pass_o |-> done_o);

  assert_done_quiet_port_R7: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !mem_we_o);

  assert_end_raises_done_R7: assert property (@(posedge clk) disable iff (rst)
    run_end |=> done_o);

endmodule

// File: tb/test_bgpat_mem_tester.sv
module test_bgpat_mem_tester;

  localparam int CLK_PERIOD = 10;
  localparam int AW   = 6;
  localparam int DW   = 8;
  localparam int LAST = 44;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic          done, pass, we;
  logic [AW-1:0] addr, f_addr;
  logic [DW-1:0] wdata, f_mask;
  logic [DW-1:0] rdata = '0;
  logic [1:0]    f_pat;

  int n_chk = 0;
  int n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bgpat_mem_tester #(.ADDR_W(AW), .DATA_W(DW), .LAST_ADDR(LAST)) i_bgpat_mem_tester (
    .clk(clk), .rst(rst), .start_i(start), .done_o(done), .pass_o(pass),
    .mem_addr_o(addr), .mem_we_o(we), .mem_wdata_o(wdata), .mem_rdata_i(rdata),
    .fail_addr_o(f_addr), .fail_pat_o(f_pat), .fail_mask_o(f_mask)
  );

  // fault configuration of the behavioural RAM
  int          fa1, fa2, br_addr, br_bit, br_kind;
  logic [DW-1:0] sa1_1, sa0_1, sa1_2, sa0_2;
  logic [DW-1:0] mem [0:LAST];

  function automatic logic [DW-1:0] wr_fault(input int a, input logic [DW-1:0] d);
    logic [DW-1:0] r;
    logic v;
    r = d;
    if (br_kind != 0 && a == br_addr) begin
      v = (br_kind == 1) ? (d[br_bit] & d[br_bit+1]) : (d[br_bit] | d[br_bit+1]);
      r[br_bit] = v;
      r[br_bit+1] = v;
    end
    return r;
  endfunction

  function automatic logic [DW-1:0] rd_fault(input int a, input logic [DW-1:0] d);
    logic [DW-1:0] r;
    r = d;
    if (a == fa1) r = (r | sa1_1) & ~sa0_1;
    if (a == fa2) r = (r | sa1_2) & ~sa0_2;
    return r;
  endfunction

  always @(posedge clk) begin
    if (we) mem[addr] <= wr_fault(int'(addr), wdata);
    else if (int'(addr) <= LAST) rdata <= rd_fault(int'(addr), mem[addr]);
  end

  task automatic clear_faults();
    fa1 = -1; fa2 = -1; br_addr = -1; br_kind = 0; br_bit = 0;
    sa1_1 = '0; sa0_1 = '0; sa1_2 = '0; sa0_2 = '0;
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // independent background model: ones count from pattern index and parity
  function automatic logic [DW-1:0] sb_word(input int p, input int a);
    logic [DW-1:0] w;
    for (int i = 0; i < DW; i++) begin
      case (p)
        0: w[i] = 1'b0;
        1: w[i] = 1'b1;
        2: w[i] = ((i + a) % 2) == 1;
        default: w[i] = ((i + a) % 2) == 0;
      endcase
    end
    return w;
  endfunction

  typedef struct {
    logic          we;
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    int            p;
  } op_t;

  op_t q[$];
  bit  armed = 1'b0;

  // monitor: one expected port operation per cycle while armed
  always @(negedge clk) begin
    op_t e;
    if (armed && q.size() > 0) begin
      e = q.pop_front();
      if (e.we) begin
        check(we === 1'b1 && addr === e.a && wdata === e.d,
              (e.p >= 2) ? "R4" : "R3", "write op {we,addr,data}",
              {15'd0, we, addr, 2'd0, wdata}, {15'd0, 1'b1, e.a, 2'd0, e.d});
      end else begin
        check(we === 1'b0 && addr === e.a, "R3/R5", "read op {we,addr}",
              {23'd0, we, 2'd0, addr}, {23'd0, 1'b0, 2'd0, e.a});
      end
    end
  end

  task automatic load_expected();
    op_t o;
    q.delete();
    for (int p = 0; p < 4; p++) begin
      for (int a = 0; a <= LAST; a++) begin
        o.we = 1'b1; o.a = AW'(a); o.d = sb_word(p, a); o.p = p;
        q.push_back(o);
      end
      for (int a = 0; a <= LAST; a++) begin
        o.we = 1'b0; o.a = AW'(a); o.d = '0; o.p = p;
        q.push_back(o);
      end
    end
  endtask

  task automatic kick();
    @(negedge clk) start = 1'b1;
    @(posedge clk);
    #1 start = 1'b0;
    armed = 1'b1;
  endtask

  task automatic run(input string tag, input bit exp_pass, input int ea,
                     input int ep, input logic [DW-1:0] em, input bit poke_start);
    load_expected();
    kick();
    if (poke_start) begin
      repeat (150) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    wait (q.size() == 0);
    @(negedge clk);
    check(done === 1'b0, "R7", {tag, " done low in drain cycle"}, done, 0);
    @(negedge clk);
    check(done === 1'b1, "R7", {tag, " done after last compare"}, done, 1);
    check(pass === exp_pass, "R7", {tag, " pass flag"}, pass, exp_pass);
    check(f_addr === AW'(ea), "R8", {tag, " first fail address"}, f_addr, ea);
    check(f_pat === 2'(ep), "R8", {tag, " first fail pattern"}, f_pat, ep);
    check(f_mask === em, "R8", {tag, " first fail mask"}, f_mask, em);
    repeat (3) @(negedge clk);
    check(done === 1'b1 && we === 1'b0, "R7", {tag, " done holds, port quiet"},
          {done, we}, 2'b10);
    armed = 1'b0;
  endtask

  task automatic finish_up();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_up();
  end

  initial begin
    clear_faults();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check(done === 0 && pass === 0 && we === 0, "R1", "reset {done,pass,we}",
          {done, pass, we}, 0);
    check(f_addr === 0 && f_pat === 0 && f_mask === 0, "R1", "reset capture",
          {f_addr, f_pat, f_mask}, 0);

    // fault-free run with a start pulse in the middle (R2 ignored start)
    run("clean+R2", 1'b1, 0, 0, '0, 1'b1);

    // stuck-at-1 seen in the zeros pass (R8)
    clear_faults(); fa1 = 5; sa1_1 = 8'h08;
    run("sa1", 1'b0, 5, 0, 8'h08, 1'b0);

    // R10: next clean run clears the previous result
    clear_faults();
    run("R10 clean after fail", 1'b1, 0, 0, '0, 1'b0);

    // stuck-at-0 seen in the ones pass
    clear_faults(); fa1 = 17; sa0_1 = 8'h40;
    run("sa0", 1'b0, 17, 1, 8'h40, 1'b0);

    // AND bridge between bits 2 and 3 at odd address: checkerboard pass (R4)
    clear_faults(); br_addr = 9; br_bit = 2; br_kind = 1;
    run("R4 and-bridge", 1'b0, 9, 2, 8'h04, 1'b0);

    // OR bridge between bits 4 and 5 at even address (R4)
    clear_faults(); br_addr = 30; br_bit = 4; br_kind = 2;
    run("R4 or-bridge", 1'b0, 30, 2, 8'h10, 1'b0);

    // R6: fault at the last address, caught through the pipelined compare
    clear_faults(); fa1 = LAST; sa1_1 = 8'h80;
    run("R6 last addr", 1'b0, LAST, 0, 8'h80, 1'b0);

    // R9: two faults; first one wins, run still finishes
    clear_faults(); fa1 = 40; sa1_1 = 8'h01; fa2 = 2; sa0_2 = 8'h20;
    run("R9 two faults", 1'b0, 40, 0, 8'h01, 1'b0);

    // R1: reset in the middle of a failing run
    clear_faults(); fa1 = 3; sa1_1 = 8'h02;
    load_expected();
    kick();
    wait (f_mask !== '0);
    armed = 1'b0;
    q.delete();
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    check(done === 0 && pass === 0 && we === 0 && f_mask === 0 && f_addr === 0,
          "R1", "mid-run reset {done,pass,we,mask}", {done, pass, we, f_mask}, 0);
    repeat (5) @(negedge clk);
    check(we === 0 && addr === 0, "R1", "idle after reset {we,addr}", {we, addr}, 0);

    clear_faults();
    run("after reset", 1'b1, 0, 0, '0, 1'b0);

    finish_up();
  end

endmodule